// File: doc/BRIEF.md
# Duplicated Shift-Train Upset Monitor

This block watches for bit upsets in a field of flip-flop shift trains. An on-block 15-stage maximal-length LFSR produces one pseudo-random serial stream. That stream feeds a set of columns. Each column holds two identical trains, side A and side B, and both sides load the same bit on every enabled cycle. A column reports a mismatch when the last stages of its two trains disagree. Because each column reports on its own bit, a flagged error can be traced to a region of the fabric. Train length and column count are parameters, so the area the fabric covers can be tuned.

A second check covers a fault that corrupts both trains of one column in the same way. On a fault-free fabric every side-A tail holds the same bit, so with an even number of columns the XOR of all side-A tails is zero. A one in that XOR increments a saturating counter. The design assumes at most one upset at a time. Two side-A faults in the same cycle cancel in the XOR and are not counted.

The per-column mismatch vector and a sticky summary flag are registered. After reset, or after a flush that zeroes the trains, the comparators stay masked until the trains have been refilled with real stream data.

Top module: `upset_train_monitor`

## Requirements
- R1: The stimulus register is 15 bits wide and resets to 15'h0001. `stim_bit` is its bit 14. On each cycle with `shift_en` high the register takes {bits 13..0, bit14 XOR bit13}. It holds its value when `shift_en` is low, so the stream repeats every 32767 enabled cycles.
- R2: On each cycle with `shift_en` high, both trains of every column load `stim_bit`. On a fault-free fabric, once unmasked, no column reports a mismatch.
- R3: `col_mismatch[i]` is a registered copy of (side-A tail XOR side-B tail) for column i. It is updated every cycle, so the bit appears one clock after the tails first differ.
- R4: `any_mismatch` is set on the clock edge where any column's tails differ while unmasked. It stays set until `clear` is high at a clock edge. When a set condition and `clear` fall on the same edge, `clear` wins.
- R5: On each clock edge with `shift_en` high, the comparators unmasked and no flush, `xcol_errs` goes up by one if the XOR of all side-A tails is 1. It does not change on any other edge except a clear.
- R6: `xcol_errs` is 16 bits wide. It stops at 16'hFFFF and returns to zero on an edge with `clear` high.
- R7: A fault that sets both trains of one column to the same wrong value leaves that column's `col_mismatch` bit at 0 and increments `xcol_errs` by one.
- R8: Wrong side-A tails in two different columns in the same cycle set both column bits but leave `xcol_errs` unchanged.
- R9: After reset or a flush, the comparators are masked until `shift_en` has been high on TRAIN_LEN edges. While masked, `col_mismatch` stays 0, `any_mismatch` is not set and `xcol_errs` does not count.
- R10: On an edge with `flush` high, all trains are zeroed and the mask restarts. `col_mismatch` is 0 on the next cycle. The stimulus register is not affected.
- R11: After reset, `stim_bit`, `col_mismatch`, `any_mismatch` and `xcol_errs` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| shift_en | input | 1 | Advances the stimulus register and all trains |
| flush | input | 1 | Zeroes all trains and restarts the comparator mask |
| clear | input | 1 | Clears the summary flag and the cross-column counter |
| stim_bit | output | 1 | Serial pseudo-random stream fed to every train |
| col_mismatch | output | NUM_COLS | Registered per-column tail mismatch |
| any_mismatch | output | 1 | Sticky flag: some column mismatched since the last clear |
| xcol_errs | output | CNT_W | Saturating count of cross-column parity errors |

## Verification
The bound checker watches, on every cycle, the rules that hold for any stimulus. It checks that masked or just-flushed cycles produce no column mismatch, that the summary flag stays set until a clear and drops after one, and that the counter moves by at most one per cycle, stands still without `shift_en`, sticks at all ones and zeroes on a clear. It also checks that the stream holds while shifting is stopped. The actual detection outcomes need the bench, which corrupts train tails during chosen cycles. Those outcomes are the side-only versus both-side fault signatures, the two-fault cancellation, the exact cycle on which the mask lifts, the 32767-cycle stream period and the saturation value.

// File: rtl/utm_pkg.sv
// Shared constants and types for the upset train monitor.
// Assumes a 15-stage Fibonacci LFSR with feedback from its two top stages.
package utm_pkg;
    localparam int LFSR_W = 15;
    localparam int LFSR_TAP_HI = 14;
    localparam int LFSR_TAP_LO = 13;
    typedef logic [LFSR_W-1:0] lfsr_state_t;
    localparam lfsr_state_t LFSR_SEED = 15'h0001;
endpackage

// File: rtl/utm_lfsr.sv
// Serial pseudo-random source: maximal-length LFSR stepped by an enable.
// Assumes a nonzero seed; the all-zero state is never reached from it.
module utm_lfsr
    import utm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic bit_out
);
    lfsr_state_t state_q;

    // Advance the register one position per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= LFSR_SEED;
        else if (step)
            state_q <= {state_q[LFSR_W-2:0], state_q[LFSR_TAP_HI] ^ state_q[LFSR_TAP_LO]};
    end

    assign bit_out = state_q[LFSR_W-1];
endmodule

// File: rtl/utm_train.sv
// One shift train of LEN flip-flops with a synchronous flush to zero.
// Assumes LEN >= 2. The tail is the oldest bit held.
module utm_train #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic en,
    input  logic din,
    output logic tail
);
    logic [LEN-1:0] stage_q;

    // Shift the new bit in at stage 0; flush or reset empties the train.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= '0;
        else if (flush)
            stage_q <= '0;
        else if (en)
            stage_q <= {stage_q[LEN-2:0], din};
    end

    assign tail = stage_q[LEN-1];
endmodule

// File: rtl/utm_column.sv
// A duplicated column: two identical trains fed by the same bit.
// The tails are compared here; the side-A tail also goes out for the cross-column check.
module utm_column #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic en,
    input  logic din,
    output logic a_tail,
    output logic differ
);
    logic b_tail;

    utm_train #(.LEN(LEN)) u_a (
        .clk(clk), .rst_n(rst_n), .flush(flush), .en(en), .din(din), .tail(a_tail)
    );

    utm_train #(.LEN(LEN)) u_b (
        .clk(clk), .rst_n(rst_n), .flush(flush), .en(en), .din(din), .tail(b_tail)
    );

    // Two-input comparison of the column's tails.
    assign differ = a_tail ^ b_tail;
endmodule

// File: rtl/utm_fill_mask.sv
// Counts enabled cycles after reset or flush and arms the comparators
// once LEN fresh bits have reached every tail.
module utm_fill_mask #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic en,
    output logic armed
);
    localparam int FW = $clog2(LEN + 1);
    localparam logic [FW-1:0] FULL = FW'(LEN);

    logic [FW-1:0] fill_q;

    // Count enabled cycles up to the train length, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill_q <= '0;
        else if (flush)
            fill_q <= '0;
        else if (en && (fill_q != FULL))
            fill_q <= fill_q + 1'b1;
    end

    assign armed = (fill_q == FULL);
endmodule

// File: rtl/utm_xcol_counter.sv
// Cross-column parity check on the side-A tails with a saturating tally.
// Assumes an even column count, so that a fault-free fabric gives parity zero.
module utm_xcol_counter #(
    parameter int NUM_COLS = 16,
    parameter int CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                sample,
    input  logic [NUM_COLS-1:0] a_tails,
    output logic [CNT_W-1:0]    count
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic parity_err;
    logic [CNT_W-1:0] count_q;

    // Odd parity across the side-A tails means one tail disagrees with the rest.
    assign parity_err = ^a_tails;

    // Tally parity errors on sampled cycles and stop at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (clear)
            count_q <= '0;
        else if (sample && parity_err && (count_q != TOP))
            count_q <= count_q + 1'b1;
    end

    assign count = count_q;
endmodule

// File: rtl/upset_train_monitor.sv
// Top of the upset monitor: stimulus LFSR, NUM_COLS duplicated columns,
// fill mask, registered per-column mismatch, sticky summary flag and the
// cross-column parity counter. Assumes at most one upset per cycle and an
// even NUM_COLS.
module upset_train_monitor #(
    parameter int NUM_COLS  = 16,
    parameter int TRAIN_LEN = 16,
    parameter int CNT_W     = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic                flush,
    input  logic                clear,
    output logic                stim_bit,
    output logic [NUM_COLS-1:0] col_mismatch,
    output logic                any_mismatch,
    output logic [CNT_W-1:0]    xcol_errs
);
    logic                armed;
    logic                compare_ok;
    logic [NUM_COLS-1:0] a_tail_vec;
    logic [NUM_COLS-1:0] diff_vec;
    logic [NUM_COLS-1:0] col_mismatch_q;
    logic                any_mismatch_q;

    utm_lfsr u_lfsr (
        .clk(clk), .rst_n(rst_n), .step(shift_en), .bit_out(stim_bit)
    );

    utm_fill_mask #(.LEN(TRAIN_LEN)) u_mask (
        .clk(clk), .rst_n(rst_n), .flush(flush), .en(shift_en), .armed(armed)
    );

    // One duplicated column per region of the fabric.
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        utm_column #(.LEN(TRAIN_LEN)) u_col (
            .clk(clk), .rst_n(rst_n), .flush(flush), .en(shift_en),
            .din(stim_bit), .a_tail(a_tail_vec[c]), .differ(diff_vec[c])
        );
    end

    assign compare_ok = armed && !flush;

    // Register the per-column comparison, forced to zero while masked or flushing.
    always_ff @(posedge clk) begin
        if (!rst_n)
            col_mismatch_q <= '0;
        else if (!compare_ok)
            col_mismatch_q <= '0;
        else
            col_mismatch_q <= diff_vec;
    end

    // Sticky summary flag; clear takes priority over a new mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            any_mismatch_q <= 1'b0;
        else if (clear)
            any_mismatch_q <= 1'b0;
        else if (compare_ok && (|diff_vec))
            any_mismatch_q <= 1'b1;
    end

    utm_xcol_counter #(.NUM_COLS(NUM_COLS), .CNT_W(CNT_W)) u_xcol (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .sample(compare_ok && shift_en), .a_tails(a_tail_vec), .count(xcol_errs)
    );

    assign col_mismatch = col_mismatch_q;
    assign any_mismatch = any_mismatch_q;
endmodule

// File: rtl/upset_train_monitor_chk.sv
// Cycle-by-cycle rules of the upset monitor, bound onto the top module.
// Watches the ports plus the internal comparator-armed signal.
module upset_train_monitor_chk #(
    parameter int NUM_COLS = 16,
    parameter int CNT_W    = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                shift_en,
    input logic                flush,
    input logic                clear,
    input logic                stim_bit,
    input logic [NUM_COLS-1:0] col_mismatch,
    input logic                any_mismatch,
    input logic [CNT_W-1:0]    xcol_errs,
    input logic                armed
);
    assert_stim_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(stim_bit));

    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> (col_mismatch == '0));

    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ((col_mismatch == '0) && !armed));

    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (any_mismatch && !clear) |=> any_mismatch);

    assert_clear_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !any_mismatch);

    assert_col_implies_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|col_mismatch) |-> (any_mismatch || $past(clear)));

    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((xcol_errs == $past(xcol_errs)) || (xcol_errs == $past(xcol_errs) + 1'b1)));

    assert_cnt_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !clear) |=> $stable(xcol_errs));

    assert_cnt_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((xcol_errs == '1) && !clear) |=> (xcol_errs == '1));

    assert_cnt_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (xcol_errs == '0));
endmodule

bind upset_train_monitor upset_train_monitor_chk #(
    .NUM_COLS(NUM_COLS), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .flush(flush), .clear(clear),
    .stim_bit(stim_bit), .col_mismatch(col_mismatch), .any_mismatch(any_mismatch),
    .xcol_errs(xcol_errs), .armed(armed)
);

// File: tb/upset_train_monitor_tb.sv
`timescale 1ns/1ps
module upset_train_monitor_tb;
    localparam int N = 16;
    localparam int L = 16;

    typedef struct packed {
        logic [7:0]  pre;
        logic [2:0]  kind;    // 0 A only, 1 B only, 2 both sides, 3 A in two columns, 4 none
        logic [3:0]  col_x;
        logic [3:0]  col_y;
        logic [15:0] exp_vec;
        logic        exp_inc;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{8'd5,  3'd0, 4'd3,  4'd0,  16'h0008, 1'b1},
        '{8'd9,  3'd1, 4'd15, 4'd0,  16'h8000, 1'b0},
        '{8'd2,  3'd2, 4'd7,  4'd0,  16'h0000, 1'b1},
        '{8'd13, 3'd3, 4'd0,  4'd15, 16'h8001, 1'b0},
        '{8'd0,  3'd1, 4'd0,  4'd0,  16'h0001, 1'b0},
        '{8'd21, 3'd2, 4'd15, 4'd0,  16'h0000, 1'b1},
        '{8'd0,  3'd4, 4'd0,  4'd0,  16'h0000, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shift_en = 1'b0;
    logic flush = 1'b0;
    logic clear = 1'b0;
    logic stim_bit;
    logic [N-1:0] col_mismatch;
    logic any_mismatch;
    logic [15:0] xcol_errs;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [14:0] model_lfsr = 15'h0001;
    logic [L-1:0] model_train = '0;
    logic fval_x = 1'b0;
    logic fval_y = 1'b0;
    logic first_bits [64];

    upset_train_monitor #(.NUM_COLS(N), .TRAIN_LEN(L), .CNT_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .flush(flush), .clear(clear),
        .stim_bit(stim_bit), .col_mismatch(col_mismatch),
        .any_mismatch(any_mismatch), .xcol_errs(xcol_errs)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock with the given enable; models the stream and a train per R1/R2.
    task automatic step(input bit en);
        shift_en = en;
        @(posedge clk);
        if (en) begin
            model_train = {model_train[L-2:0], model_lfsr[14]};
            model_lfsr = {model_lfsr[13:0], model_lfsr[14] ^ model_lfsr[13]};
        end
        @(negedge clk);
        shift_en = 1'b0;
        chk("R1 stim_bit", {31'd0, stim_bit}, {31'd0, model_lfsr[14]});
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(posedge clk);
        model_train = '0;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic do_clear();
        clear = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clear = 1'b0;
    endtask

    // Upset injection on a tail stage; columns 0 and 7 take fval_x, 3 and 15 fval_y.
    task put_fault(input int col, input bit side_b);
        case (col)
            0:  if (side_b) force u_dut.g_col[0].u_col.u_b.stage_q[15] = fval_x;
                else        force u_dut.g_col[0].u_col.u_a.stage_q[15] = fval_x;
            3:  if (side_b) force u_dut.g_col[3].u_col.u_b.stage_q[15] = fval_y;
                else        force u_dut.g_col[3].u_col.u_a.stage_q[15] = fval_y;
            7:  if (side_b) force u_dut.g_col[7].u_col.u_b.stage_q[15] = fval_x;
                else        force u_dut.g_col[7].u_col.u_a.stage_q[15] = fval_x;
            15: if (side_b) force u_dut.g_col[15].u_col.u_b.stage_q[15] = fval_y;
                else        force u_dut.g_col[15].u_col.u_a.stage_q[15] = fval_y;
            default: ;
        endcase
    endtask

    task release_all();
        release u_dut.g_col[0].u_col.u_a.stage_q[15];
        release u_dut.g_col[0].u_col.u_b.stage_q[15];
        release u_dut.g_col[3].u_col.u_a.stage_q[15];
        release u_dut.g_col[3].u_col.u_b.stage_q[15];
        release u_dut.g_col[7].u_col.u_a.stage_q[15];
        release u_dut.g_col[7].u_col.u_b.stage_q[15];
        release u_dut.g_col[15].u_col.u_a.stage_q[15];
        release u_dut.g_col[15].u_col.u_b.stage_q[15];
    endtask

    task automatic restart(input int fills);
        do_flush();
        do_clear();
        repeat (fills) step(1'b1);
    endtask

    initial begin
        // Reset state (R11)
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11 stim_bit", {31'd0, stim_bit}, 32'd0);
        chk("R11 col_mismatch", {16'd0, col_mismatch}, 32'd0);
        chk("R11 any_mismatch", {31'd0, any_mismatch}, 32'd0);
        chk("R11 xcol_errs", {16'd0, xcol_errs}, 32'd0);

        // Vector table: one upset pattern per entry, checked one edge later (R3 R5 R7 R8 R2)
        for (int v = 0; v < 7; v++) begin
            restart(L + int'(VECS[v].pre));
            fval_x = ~model_train[L-1];
            fval_y = ~model_train[L-1];
            case (VECS[v].kind)
                3'd0: put_fault(int'(VECS[v].col_x), 1'b0);
                3'd1: put_fault(int'(VECS[v].col_x), 1'b1);
                3'd2: begin put_fault(int'(VECS[v].col_x), 1'b0); put_fault(int'(VECS[v].col_x), 1'b1); end
                3'd3: begin put_fault(int'(VECS[v].col_x), 1'b0); put_fault(int'(VECS[v].col_y), 1'b0); end
                default: ;
            endcase
            step(1'b1);
            chk("R3 R7 R8 col_mismatch", {16'd0, col_mismatch}, {16'd0, VECS[v].exp_vec});
            chk("R4 any_mismatch", {31'd0, any_mismatch}, {31'd0, VECS[v].exp_vec != 16'd0});
            chk("R5 R7 R8 xcol_errs", {16'd0, xcol_errs}, {31'd0, VECS[v].exp_inc});
            release_all();
        end

        // Mask right after flush: masked parity must not count (R9)
        restart(3);
        fval_y = 1'b1;
        put_fault(3, 1'b0);
        step(1'b1);
        chk("R9 masked count", {16'd0, xcol_errs}, 32'd0);
        chk("R9 masked col", {16'd0, col_mismatch}, 32'd0);
        release_all();

        // Mask lifts exactly after L enabled cycles (R9)
        restart(L - 1);
        fval_x = ~model_train[L-1];
        put_fault(7, 1'b1);
        step(1'b1);
        chk("R9 last masked edge", {16'd0, col_mismatch}, 32'd0);
        chk("R9 flag still low", {31'd0, any_mismatch}, 32'd0);
        fval_x = ~model_train[L-1];
        step(1'b0);
        chk("R9 first armed edge", {16'd0, col_mismatch}, 32'h0080);
        release_all();

        // Clean stream for many cycles raises nothing (R2)
        restart(L);
        repeat (40) step(1'b1);
        chk("R2 clean col", {16'd0, col_mismatch}, 32'd0);
        chk("R2 clean flag", {31'd0, any_mismatch}, 32'd0);
        chk("R2 clean count", {16'd0, xcol_errs}, 32'd0);

        // Stream holds while shifting is stopped (R1); checked inside step
        repeat (5) step(1'b0);

        // Sticky flag and clear priority (R4), flush zeroes the vector (R10)
        fval_y = ~model_train[L-1];
        put_fault(3, 1'b1);
        step(1'b0);
        release_all();
        repeat (3) step(1'b1);
        chk("R4 column recovered", {16'd0, col_mismatch}, 32'd0);
        chk("R4 flag sticky", {31'd0, any_mismatch}, 32'd1);
        fval_y = ~model_train[L-1];
        put_fault(3, 1'b1);
        clear = 1'b1;
        step(1'b0);
        clear = 1'b0;
        chk("R4 clear wins", {31'd0, any_mismatch}, 32'd0);
        chk("R3 column during clear", {16'd0, col_mismatch}, 32'h0008);
        step(1'b0);
        chk("R4 flag sets again", {31'd0, any_mismatch}, 32'd1);
        release_all();
        do_flush();
        chk("R10 flush zeroes col", {16'd0, col_mismatch}, 32'd0);
        step(1'b1);
        chk("R10 stream unaffected", {31'd0, stim_bit}, {31'd0, model_lfsr[14]});

        // Saturation with a steady parity error, and stream period (R6 R1)
        restart(L);
        fval_x = 1'b1;
        fval_y = 1'b0;
        put_fault(0, 1'b0);
        put_fault(3, 1'b0);
        for (int k = 0; k < 65540; k++) begin
            if (k < 64)
                first_bits[k] = stim_bit;
            else if (k >= 32767 && k < 32767 + 64)
                chk("R1 period 32767", {31'd0, stim_bit}, {31'd0, first_bits[k - 32767]});
            step(1'b1);
        end
        chk("R6 saturated", {16'd0, xcol_errs}, 32'h0000FFFF);
        step(1'b1);
        chk("R6 stays saturated", {16'd0, xcol_errs}, 32'h0000FFFF);
        release_all();
        do_flush();
        do_clear();
        chk("R6 clear count", {16'd0, xcol_errs}, 32'd0);
        chk("R4 clear flag", {31'd0, any_mismatch}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule